// File: doc/BRIEF.md
# Slow-Clock Aligned Wait Generator

This block sits between a bus controller whose pattern engine runs on a fast clock and a synchronous slave port clocked at one half or one third of that rate. At the start of each access pattern the engine drives one of its general-purpose control lines to its non-idle level to ask for alignment. The block answers by holding the engine's wait input high until the next slave-clock cycle begins. When the control line returns to idle, the block hands the wait input over to the slave's transfer acknowledge for the rest of the bus cycle. Wait is the inverse of the acknowledge: the engine is stalled until the slave acknowledges.

The slave-clock phase is tracked in the fast domain by a sub-cycle counter. A phase-start strobe restarts it, and between strobes it wraps at the selected ratio. The acknowledge normally passes through a two-flop synchronizer. At the 2x ratio a direct path can be chosen instead, for slaves whose acknowledge timing already meets the fast clock. Wait is always taken from a register, so it does not glitch when the source changes.

The block has no data stream and no valid/ready handshake. All of its pins are plain control levels, sampled on every fast-clock edge.

Top module: `slow_align_wait`

## Requirements
- R1: While rst_n is low, wait_out is 0. The sub-cycle counter and both acknowledge synchronizer flops are cleared.
- R2: ratio_sel = 2'b11 selects a 3x ratio, and any other value selects 2x. The current sub-cycle index is 0 in a cycle with phase_start high. Otherwise it is the stored count. An index at or beyond ratio-1 marks the last sub-cycle, and the count returns to 0 after it. Any other index stores index+1.
- R3: While the sync request is active, wait_out after the next edge is 1. The exception is a cycle that is the last sub-cycle: wait_out after that edge is 0, so that wait falls exactly at the start of a slave cycle.
- R4: line_sel picks the request line. Lines 0 to 4 idle high, and a request is recognised when the line is 0. Line 5 idles low, and a request is recognised when it is 1. line_sel values 6 and 7 never raise a request.
- R5: Without an active request, wait_out after the next edge is the inverse of the conditioned acknowledge.
- R6: On the synchronized path, the conditioned acknowledge equals slv_ack as sampled two edges earlier.
- R7: When direct_ack is 1 and the ratio is 2x, the conditioned acknowledge is the current slv_ack. At 3x, direct_ack has no effect and the synchronized path is used.
- R8: If slv_ack has been high for two or more cycles when the request drops, wait_out is 0 after the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_start | input | 1 | High in the first fast sub-cycle of a slave-clock cycle |
| ratio_sel | input | 2 | 2'b11 selects 3x; any other value selects 2x |
| line_sel | input | 3 | Index of the control line used as sync request |
| gpl_lines | input | 6 | General-purpose control lines from the pattern engine |
| direct_ack | input | 1 | Requests the unsynchronized acknowledge path (honoured at 2x only) |
| slv_ack | input | 1 | Slave transfer acknowledge, active high |
| wait_out | output | 1 | Registered wait to the pattern engine, active high |

## Verification
The bench runs four kinds of stimulus, each at both ratios. The first is idle control lines with a toggling acknowledge, which isolates the pass path and the two-cycle synchronizer delay. The second is long request bursts on each line, which shows whether wait drops only in the cycle after the last sub-cycle. The third is random control-line noise with line selects 5 to 7, which separates the line 5 polarity and the unused selects from lines 0 to 4. The last adds stray phase_start strobes and direct_ack toggling; these show whether the counter restarts on the strobe and whether the direct path is refused at 3x.

// File: rtl/saw_pkg.sv
package saw_pkg;
  localparam int NUM_LINES  = 6;
  localparam int MAX_RATIO  = 3;
  localparam int SYNC_DEPTH = 2;
  localparam int CNT_W      = $clog2(MAX_RATIO + 1);
  localparam int SEL_W      = $clog2(NUM_LINES + 2);
  // lines whose active level is high; all others are active low
  localparam logic [NUM_LINES-1:0] HIGH_ACTIVE = 6'b100000;

  typedef enum logic [1:0] {
    RSEL_X2A = 2'b00,
    RSEL_X2B = 2'b01,
    RSEL_X2C = 2'b10,
    RSEL_X3  = 2'b11
  } ratio_sel_e;
endpackage

// File: rtl/saw_phase_track.sv
module saw_phase_track
  import saw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_start,
  input  logic [CNT_W-1:0] ratio_m1,
  output logic             last_sub
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idx;

  assign idx      = phase_start ? '0 : cnt_q;
  assign last_sub = (idx >= ratio_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (last_sub) cnt_q <= '0;
    else cnt_q <= idx + 1'b1;
  end

  // R2
  strobe_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_start && ratio_m1 != '0) |=> (cnt_q == CNT_W'(1)));
  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CNT_W'(MAX_RATIO - 1)));
endmodule

// File: rtl/saw_ack_cond.sv
module saw_ack_cond
  import saw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic use_direct,
  input  logic slv_ack,
  output logic ack_c
);
  logic [SYNC_DEPTH-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_DEPTH-2:0], slv_ack};
  end

  assign ack_c = use_direct ? slv_ack : sync_q[SYNC_DEPTH-1];

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_direct && since_rst >= 2'd2) |-> (ack_c == $past(slv_ack, 2)));
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0 && !use_direct) |-> !ack_c);
endmodule

// File: rtl/saw_wait_mux.sv
module saw_wait_mux (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_req,
  input  logic last_sub,
  input  logic ack_c,
  output logic wait_q
);
  logic wait_d;

  always_comb begin
    if (sync_req) wait_d = ~last_sub;
    else          wait_d = ~ack_c;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wait_q <= 1'b0;
    else        wait_q <= wait_d;
  end

  // R3
  hold_until_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && !last_sub) |=> wait_q);
  // R3
  release_at_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && last_sub) |=> !wait_q);
  // R5
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_req |=> (wait_q == !$past(ack_c)));
endmodule

// File: rtl/slow_align_wait.sv
module slow_align_wait
  import saw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 phase_start,
  input  logic [1:0]           ratio_sel,
  input  logic [SEL_W-1:0]     line_sel,
  input  logic [NUM_LINES-1:0] gpl_lines,
  input  logic                 direct_ack,
  input  logic                 slv_ack,
  output logic                 wait_out
);
  logic [CNT_W-1:0]     ratio_m1;
  logic                 is_x3;
  logic                 use_direct;
  logic                 last_sub;
  logic                 ack_c;
  logic                 sync_req;
  logic [NUM_LINES-1:0] line_active;

  assign is_x3      = (ratio_sel == RSEL_X3);
  assign ratio_m1   = is_x3 ? CNT_W'(2) : CNT_W'(1);
  assign use_direct = direct_ack && !is_x3;

  // per-line polarity normalisation
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pol
    if (HIGH_ACTIVE[g]) begin : g_hi
      assign line_active[g] = gpl_lines[g];
    end else begin : g_lo
      assign line_active[g] = ~gpl_lines[g];
    end
  end

  assign sync_req = (32'(line_sel) < NUM_LINES) ? line_active[line_sel] : 1'b0;

  saw_phase_track u_phase (
    .clk(clk), .rst_n(rst_n), .phase_start(phase_start),
    .ratio_m1(ratio_m1), .last_sub(last_sub)
  );

  saw_ack_cond u_ack (
    .clk(clk), .rst_n(rst_n), .use_direct(use_direct),
    .slv_ack(slv_ack), .ack_c(ack_c)
  );

  saw_wait_mux u_mux (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req),
    .last_sub(last_sub), .ack_c(ack_c), .wait_q(wait_out)
  );

  // R4
  unused_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(line_sel) >= NUM_LINES) |-> !sync_req);
  // R7
  direct_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_x3 |-> !use_direct);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !wait_out);
endmodule

// File: tb/slow_align_wait_tb.sv
`timescale 1ns/1ps
module slow_align_wait_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       phase_start = 1'b0;
  logic [1:0] ratio_sel = 2'b00;
  logic [2:0] line_sel = 3'd0;
  logic [5:0] gpl_lines = 6'b011111;
  logic       direct_ack = 1'b0;
  logic       slv_ack = 1'b0;
  logic       wait_out;

  always #5 clk = ~clk;

  slow_align_wait u_dut (
    .clk(clk), .rst_n(rst_n), .phase_start(phase_start), .ratio_sel(ratio_sel),
    .line_sel(line_sel), .gpl_lines(gpl_lines), .direct_ack(direct_ack),
    .slv_ack(slv_ack), .wait_out(wait_out)
  );

  int n_vec = 0;
  int n_bad = 0;

  // behavioural reference, updated on each rising edge
  int    sub_m = 0;
  bit    h1 = 0, h2 = 0, exp_wait = 0, prev_req = 0;
  string exp_tag = "R1";

  always @(posedge clk) begin
    int  r, idx;
    bit  req, last, ackc, direct;
    if (!rst_n) begin
      sub_m = 0; h1 = 0; h2 = 0; exp_wait = 0; prev_req = 0; exp_tag = "R1";
    end else begin
      r      = (ratio_sel == 2'b11) ? 3 : 2;
      idx    = phase_start ? 0 : sub_m;
      last   = (idx >= r - 1);
      if (line_sel < 5)       req = !gpl_lines[line_sel];
      else if (line_sel == 5) req = gpl_lines[5];
      else                    req = 0;
      direct = direct_ack && (r == 2);
      ackc   = direct ? slv_ack : h2;
      if (req) begin
        exp_wait = !last;
        if (line_sel == 5) exp_tag = "R4";
        else if (phase_start && sub_m != 0) exp_tag = "R2";
        else exp_tag = "R3";
      end else begin
        exp_wait = !ackc;
        if (prev_req && ackc) exp_tag = "R8";
        else if (line_sel > 5) exp_tag = "R4";
        else if (direct) exp_tag = "R7";
        else if (direct_ack) exp_tag = "R7";
        else if (!exp_wait) exp_tag = "R6";
        else exp_tag = "R5";
      end
      sub_m    = last ? 0 : idx + 1;
      prev_req = req;
      h2 = h1; h1 = slv_ack;
    end
  end

  task automatic check_now();
    n_vec++;
    if (wait_out !== exp_wait) begin
      n_bad++;
      $display("FAIL %s: wait_out actual %0b expected %0b at %0t", exp_tag, wait_out, exp_wait, $time);
    end
  endtask

  // mode: 0 idle+ack toggle, 1 request bursts, 2 noise on lines 5..7, 3 stray strobes+direct
  task automatic run(int rsel, int mode, int n);
    int r = (rsel == 3) ? 3 : 2;
    int pc = 0;
    int burst = 0;
    @(negedge clk);
    check_now();
    rst_n = 1'b0; ratio_sel = 2'(rsel);
    gpl_lines = 6'b011111; slv_ack = 0; direct_ack = 0; phase_start = 0;
    @(negedge clk);
    check_now();               // R1: reset holds wait low
    @(negedge clk);
    check_now();
    rst_n = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      phase_start = (pc % r == 0);
      pc++;
      case (mode)
        0: begin
          line_sel  = 3'($urandom_range(0, 4));
          gpl_lines = 6'b011111;
          slv_ack   = ($urandom_range(0, 3) != 0) ? slv_ack : ~slv_ack;
        end
        1: begin
          if (burst == 0) begin
            burst    = $urandom_range(2, 9);
            line_sel = 3'($urandom_range(0, 5));
          end
          burst--;
          gpl_lines = 6'b011111;
          if (burst > 2) gpl_lines[line_sel] = ~gpl_lines[line_sel];
          slv_ack = (burst <= 3);
        end
        2: begin
          line_sel  = 3'($urandom_range(5, 7));
          gpl_lines = 6'($urandom);
          slv_ack   = 1'($urandom);
        end
        default: begin
          line_sel    = 3'($urandom_range(0, 7));
          gpl_lines   = 6'($urandom);
          slv_ack     = 1'($urandom);
          direct_ack  = 1'($urandom);
          if ($urandom_range(0, 5) == 0) phase_start = 1'b1;
        end
      endcase
    end
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      run(0, m, 600);
      run(3, m, 600);
    end
    run(1, 3, 400);            // R2: non-3 codes behave as 2x
    @(negedge clk);
    check_now();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule